// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates addresses for a synchronous memory that moves four data beats per request. When a request is loaded, it captures an external address as the start of a burst. It also records whether the burst is a read or a write. On each advance cycle it steps to the next address of the four-beat sequence. Only the two lowest address bits move. The upper bits stay at their loaded value for the whole burst.

A static ordering input picks one of two orderings. Sequential ordering adds the beat number to the start offset and wraps modulo four. Interleaved ordering XORs the start offset with the beat number.

A clock-qualify input freezes all state for as long as it is low. Three chip-select inputs of mixed polarity gate each load. A load cycle with the chip not selected ends the current burst. The memory array and the data path are not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state: after that edge `burst_active` is 0, `burst_wr` is 0 and `burst_addr` is 0.
- R2: A load cycle starts a burst. A load cycle is `run`=1, `step`=0, with the chip selected. After that edge, `burst_addr` equals the `ext_addr` sampled at the edge, `burst_active` is 1 and `burst_wr` equals the sampled `wr_req` (1 = write, 0 = read). This also applies in the middle of a burst.
- R3: With `order_il`=0 (sequential), each advance cycle moves the low two address bits from start+k to start+k+1 modulo 4. For example, start 2 gives 2, 3, 0, 1.
- R4: With `order_il`=1 (interleaved), the low two address bits equal the start offset XOR the beat number, and the beat number counts 0, 1, 2, 3. For example, start 1 gives 1, 0, 3, 2, and start 3 gives 3, 2, 1, 0.
- R5: Bits above bit 1 of `burst_addr` never change on an advance cycle. After the fourth advance the address returns to the start address and does not carry into the upper bits.
- R6: On an advance cycle (`run`=1, `step`=1), `wr_req` is ignored: `burst_wr` keeps the value latched at load.
- R7: At any edge where `run` is 0, all inputs except `rst_n` are ignored. `burst_addr`, `burst_active` and `burst_wr` keep their values.
- R8: A load cycle with the chip not selected ends the burst: `burst_active` becomes 0, while `burst_addr` and `burst_wr` keep their values.
- R9: An advance cycle with `burst_active`=0 changes nothing.
- R10: The chip is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. Any other combination counts as not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Clock qualify; 0 freezes all state |
| step | input | 1 | 0 = load a new address, 1 = advance the burst |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| wr_req | input | 1 | Direction sampled at load: 1 = write, 0 = read |
| order_il | input | 1 | Static ordering: 0 = sequential, 1 = interleaved |
| ext_addr | input | ADDR_W | External start address |
| burst_addr | output | ADDR_W | Current burst address |
| burst_active | output | 1 | A burst is in progress |
| burst_wr | output | 1 | Direction latched for the current burst |

## Verification
Each result appears one clock edge after the cycle that causes it. Loads, advances, deselects, stalls and resets all update the state registers at the edge where their inputs are sampled. The address bits are then formed combinationally from those registers and the static ordering input. So every effect is visible right after that single edge.

The bench drives each vector on a falling edge and lets one rising edge pass. It compares all three outputs on the following falling edge, before the next vector is applied. The bound properties use `|=>` with exactly one cycle of delay for the same reason.

// File: rtl/burst_pkg.sv
// Package: shared widths and the per-cycle operation code of the burst
// address sequencer. Assumes a fixed four-beat burst (two offset bits).
package burst_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,   // nothing changes
        OP_LOAD = 2'd1,   // capture a new start address
        OP_STOP = 2'd2,   // deselect: end the burst
        OP_STEP = 2'd3    // advance the beat counter
    } burst_op_e;
endpackage

// File: rtl/burst_sel_decode.sv
// Module: burst_sel_decode
// Folds the three chip-select inputs into one "selected" flag.
// Assumes two active-low selects and one active-high select.
module burst_sel_decode (
    input  logic cs_a_n,
    input  logic cs_b_n,
    input  logic cs_c,
    output logic selected
);
    // Selected only when every select is at its active level.
    always_comb begin
        selected = (!cs_a_n) && (!cs_b_n) && cs_c;
    end
endmodule

// File: rtl/burst_op_decode.sv
// Module: burst_op_decode
// Turns the control inputs into one operation per cycle.
// Assumes the run qualifier has priority over everything else.
module burst_op_decode
    import burst_pkg::*;
(
    input  logic      run,
    input  logic      step,
    input  logic      selected,
    input  logic      active,
    output burst_op_e op
);
    // Priority: stall, then load/deselect, then advance of a live burst.
    always_comb begin
        if (!run) begin
            op = OP_HOLD;
        end else if (!step) begin
            op = selected ? OP_LOAD : OP_STOP;
        end else if (active) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/burst_order.sv
// Module: burst_order
// Maps the start offset and beat number to the current low address bits.
// Assumes order_il is static for the length of a burst.
module burst_order
    import burst_pkg::*;
(
    input  logic [BEAT_W-1:0] start_ofs,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_il,
    output logic [BEAT_W-1:0] cur_ofs
);
    logic [BEAT_W-1:0] seq_ofs;
    logic [BEAT_W-1:0] il_ofs;

    // Both orderings are built; the mode input picks one.
    always_comb begin
        seq_ofs = start_ofs + beat;
        il_ofs  = start_ofs ^ beat;
        cur_ofs = order_il ? il_ofs : seq_ofs;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Four-beat burst address sequencer. It latches the start address and the
// direction on load and steps a beat counter on advance. The low bits are
// ordered sequentially or interleaved; the upper bits stay as loaded.
// Assumes ADDR_W > BEAT_W.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              cs_c,
    input  logic              wr_req,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              burst_active,
    output logic              burst_wr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic              active_q;
    logic              wr_q;
    logic              selected;
    logic [BEAT_W-1:0] cur_ofs;
    burst_op_e         op;

    burst_sel_decode u_sel (
        .cs_a_n   (cs_a_n),
        .cs_b_n   (cs_b_n),
        .cs_c     (cs_c),
        .selected (selected)
    );

    burst_op_decode u_op (
        .run      (run),
        .step     (step),
        .selected (selected),
        .active   (active_q),
        .op       (op)
    );

    burst_order u_order (
        .start_ofs (start_q),
        .beat      (beat_q),
        .order_il  (order_il),
        .cur_ofs   (cur_ofs)
    );

    // Burst state: start address, beat counter, live flag, direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            start_q  <= '0;
            beat_q   <= '0;
            active_q <= 1'b0;
            wr_q     <= 1'b0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    hi_q     <= ext_addr[ADDR_W-1:BEAT_W];
                    start_q  <= ext_addr[BEAT_W-1:0];
                    beat_q   <= '0;
                    active_q <= 1'b1;
                    wr_q     <= wr_req;
                end
                OP_STOP: active_q <= 1'b0;
                OP_STEP: beat_q   <= beat_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Output assembly: upper bits as loaded, low bits as ordered.
    always_comb begin
        burst_addr   = {hi_q, cur_ofs};
        burst_active = active_q;
        burst_wr     = wr_q;
    end
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Module: burst_addr_gen_chk
// Port-level properties of burst_addr_gen, attached by bind below.
// Assumes order_il only changes between bursts.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              step,
    input logic              cs_a_n,
    input logic              cs_b_n,
    input logic              cs_c,
    input logic              wr_req,
    input logic              order_il,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] burst_addr,
    input logic              burst_active,
    input logic              burst_wr
);
    logic sel_chk;
    // Independent view of the select condition.
    always_comb sel_chk = (cs_a_n == 1'b0) && (cs_b_n == 1'b0) && (cs_c == 1'b1);

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step && sel_chk) |=>
            (burst_active && burst_addr == $past(ext_addr) && burst_wr == $past(wr_req)));

    a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && burst_active) |=>
            (burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])));

    a_r6_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step) |=> $stable(burst_wr));

    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> ($stable(burst_active) && $stable(burst_wr) &&
                    ($stable(order_il) -> $stable(burst_addr))));

    a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step && !sel_chk) |=> (!burst_active && $stable(burst_wr)));

    a_r9_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && !burst_active) |=>
            (!burst_active && ($stable(order_il) -> $stable(burst_addr))));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .step         (step),
    .cs_a_n       (cs_a_n),
    .cs_b_n       (cs_b_n),
    .cs_c         (cs_c),
    .wr_req       (wr_req),
    .order_il     (order_il),
    .ext_addr     (ext_addr),
    .burst_addr   (burst_addr),
    .burst_active (burst_active),
    .burst_wr     (burst_wr)
);

// File: tb/tb_burst_addr_gen.sv
// Bench for burst_addr_gen: a vector table walked by one loop, then
// directed reset checks. Inputs change on falling edges; outputs are
// compared on the falling edge after the rising edge that acts on them.
module tb_burst_addr_gen;
    localparam int AW = 17;

    typedef struct packed {
        logic [3:0]    req;   // requirement number the vector targets
        logic          run;
        logic          step;
        logic [2:0]    cs;    // {cs_a_n, cs_b_n, cs_c}
        logic          wr;
        logic          il;
        logic [AW-1:0] ext;
        logic [AW-1:0] e_addr;
        logic          e_act;
        logic          e_wr;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [0:NV-1] = '{
        // R2: sequential load, start offset 2, write
        '{4'd2, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 17'h12342, 17'h12342, 1'b1, 1'b1},
        // R3 R6: advance with wr_req=0, direction stays write
        '{4'd6, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h12343, 1'b1, 1'b1},
        '{4'd3, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h12340, 1'b1, 1'b1},
        '{4'd3, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h12341, 1'b1, 1'b1},
        // R5: fourth advance wraps to the start
        '{4'd5, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h12342, 1'b1, 1'b1},
        // R7: stalled load is ignored
        '{4'd7, 1'b0, 1'b0, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h12342, 1'b1, 1'b1},
        // R4: interleaved load, start 1, read
        '{4'd4, 1'b1, 1'b0, 3'b001, 1'b0, 1'b1, 17'h0ABC5, 17'h0ABC5, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, 17'h00000, 17'h0ABC4, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, 17'h00000, 17'h0ABC7, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, 17'h00000, 17'h0ABC6, 1'b1, 1'b0},
        '{4'd5, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, 17'h00000, 17'h0ABC5, 1'b1, 1'b0},
        // R8: deselect through cs_a_n
        '{4'd8, 1'b1, 1'b0, 3'b101, 1'b1, 1'b1, 17'h1FFFF, 17'h0ABC5, 1'b0, 1'b0},
        // R9: advance with no burst changes nothing
        '{4'd9, 1'b1, 1'b1, 3'b001, 1'b1, 1'b1, 17'h00000, 17'h0ABC5, 1'b0, 1'b0},
        // R10: deselect through cs_c and through cs_b_n
        '{4'd10, 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 17'h1FFFF, 17'h0ABC5, 1'b0, 1'b0},
        '{4'd10, 1'b1, 1'b0, 3'b011, 1'b1, 1'b1, 17'h1FFFF, 17'h0ABC5, 1'b0, 1'b0},
        // R2 R5: load top address, advance wraps without carry
        '{4'd2, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 17'h1FFFF, 17'h1FFFF, 1'b1, 1'b1},
        '{4'd5, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h1FFFC, 1'b1, 1'b1},
        // R7: stalled advance holds
        '{4'd7, 1'b0, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h1FFFC, 1'b1, 1'b1},
        '{4'd3, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h1FFFD, 1'b1, 1'b1},
        // R4: interleaved start 3 gives 3,2,1,0
        '{4'd4, 1'b1, 1'b0, 3'b001, 1'b0, 1'b1, 17'h00003, 17'h00003, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 17'h00000, 17'h00002, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 17'h00000, 17'h00001, 1'b1, 1'b0},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 17'h00000, 17'h00000, 1'b1, 1'b0},
        // R2: reload mid-burst, interleaved start 2
        '{4'd2, 1'b1, 1'b0, 3'b001, 1'b1, 1'b1, 17'h05556, 17'h05556, 1'b1, 1'b1},
        '{4'd4, 1'b1, 1'b1, 3'b001, 1'b0, 1'b1, 17'h00000, 17'h05557, 1'b1, 1'b1},
        // R3: sequential start 2 on the same burst address space
        '{4'd2, 1'b1, 1'b0, 3'b001, 1'b0, 1'b0, 17'h08882, 17'h08882, 1'b1, 1'b0},
        '{4'd3, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0, 17'h00000, 17'h08883, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0, step = 1'b0;
    logic          cs_a_n = 1'b1, cs_b_n = 1'b1, cs_c = 1'b0;
    logic          wr_req = 1'b0, order_il = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] burst_addr;
    logic          burst_active, burst_wr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .step         (step),
        .cs_a_n       (cs_a_n),
        .cs_b_n       (cs_b_n),
        .cs_c         (cs_c),
        .wr_req       (wr_req),
        .order_il     (order_il),
        .ext_addr     (ext_addr),
        .burst_addr   (burst_addr),
        .burst_active (burst_active),
        .burst_wr     (burst_wr)
    );

    task automatic check(input int req, input string what,
                         input logic [AW-1:0] ea, input logic eact, input logic ewr);
        n_chk++;
        if (burst_addr !== ea || burst_active !== eact || burst_wr !== ewr) begin
            n_err++;
            $display("FAIL R%0d %s: got addr=%h act=%b wr=%b, expected addr=%h act=%b wr=%b",
                     req, what, burst_addr, burst_active, burst_wr, ea, eact, ewr);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, "reset state", '0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run      = VEC[i].run;
            step     = VEC[i].step;
            {cs_a_n, cs_b_n, cs_c} = VEC[i].cs;
            wr_req   = VEC[i].wr;
            order_il = VEC[i].il;
            ext_addr = VEC[i].ext;
            @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i].req), $sformatf("vector %0d", i),
                  VEC[i].e_addr, VEC[i].e_act, VEC[i].e_wr);
        end

        // R1: reset in the middle of a burst clears everything
        run = 1'b1; step = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(1, "reset mid-burst", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R9: advance right after reset stays idle
        @(posedge clk);
        @(negedge clk);
        check(9, "advance after reset", '0, 1'b0, 1'b0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule